// File: doc/BRIEF.md
# Waveform Readout Address Generator

This block sequences the addresses needed to move stored analog samples out of a switched-capacitor sampling array and into a waveform buffer. A single start pulse launches a readout. The generator then visits a programmable, ascending range of channel addresses. For each channel it emits one full channel depth of cell indices, one per clock. Alongside each cell index it drives a buffer write address and a write strobe.

Cell order within a channel can be plain, beginning at cell 0, or rotated. In rotated order the walk begins at the cell where sampling last stopped and wraps around, so the buffer holds the samples in time order. A cascade configuration byte chains physical channels together, which sets the depth of each logical channel to one, two, four or eight times the physical cell count. When the last sample has been written, a one-cycle done pulse is raised and the block returns to idle.

Top module: `wave_readout_addr`

## Requirements
- R1: After reset, busy, write enable and done are low, and the cell index, channel address and write address are zero.
- R2: A start pulse seen while idle begins the readout: the first sample appears in the cycle after the start edge. A start seen while busy has no effect.
- R3: With the rotate input at 0, every channel's walk begins at cell 0. With it at 1, every channel's walk begins at the stop-cell input taken modulo the channel depth.
- R4: Within a channel the cell index rises by one per sample and wraps modulo the depth, so exactly one depth of samples is emitted per channel.
- R5: The channel depth is selected by the cascade byte: 0x01 gives 8×CELLS, 0x11 gives 4×CELLS, 0x33 gives 2×CELLS and 0xFF gives CELLS. Any other value gives CELLS.
- R6: Channels are visited in ascending order, from the first-channel input to the last-channel input inclusive.
- R7: If the last-channel input is below the first-channel input, only the first channel is read.
- R8: The write address is 0 on the first sample and rises by one on every sample across all channels. Write enable is high exactly on sample cycles.
- R9: Done is high for one cycle, in the cycle after the final sample, with busy low. The block is then idle.
- R10: Mode, channel range, cascade byte and stop cell are captured at start. Changes to them during a readout have no effect on that readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a readout (accepted when idle) |
| rotate | input | 1 | 0: begin at cell 0; 1: begin at stop cell |
| first_chn | input | CHW | First channel address to read |
| last_chn | input | CHW | Last channel address to read |
| casc_cfg | input | 8 | Cascade configuration byte |
| stop_cell | input | CW | Cell where sampling stopped at the last trigger |
| busy | output | 1 | Readout in progress |
| cell_idx | output | CW | Cell index of the current sample |
| chan_addr | output | CHW | Channel address of the current sample |
| ram_addr | output | AW | Waveform buffer write address |
| ram_we | output | 1 | Buffer write enable |
| done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The bench targets several edge cases, and each would show a distinct failure.

- **Stop cell beyond the depth:** the stop cell is set past the configured depth under the narrowest cascade. A generator that does not reduce the stop cell modulo the depth would emit cell indices outside the channel.
- **Reversed channel range:** a range with last below first is applied. A wrong comparison would read nothing or run away across channels.
- **Rotated multi-channel readout:** this catches a design that resumes the next channel from cell 0, or from where the previous channel ended, instead of from the stop cell.
- **Mid-readout changes:** a new start and altered configuration are applied during a readout. A design that restarts or re-reads its inputs would corrupt the sequence or its length.

// File: rtl/wave_readout_addr.sv
module wave_readout_addr #(
  parameter int CELLS = 1024,
  parameter int CHW   = 4,
  localparam int CW   = $clog2(8 * CELLS),
  localparam int AW   = CW + CHW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           rotate,
  input  logic [CHW-1:0] first_chn,
  input  logic [CHW-1:0] last_chn,
  input  logic [7:0]     casc_cfg,
  input  logic [CW-1:0]  stop_cell,
  output logic           busy,
  output logic [CW-1:0]  cell_idx,
  output logic [CHW-1:0] chan_addr,
  output logic [AW-1:0]  ram_addr,
  output logic           ram_we,
  output logic           done
);
  localparam logic [CW-1:0] M8 = CW'(8 * CELLS - 1);
  localparam logic [CW-1:0] M4 = CW'(4 * CELLS - 1);
  localparam logic [CW-1:0] M2 = CW'(2 * CELLS - 1);
  localparam logic [CW-1:0] M1 = CW'(CELLS - 1);

  logic           run, done_q;
  logic [CW-1:0]  mask_q, base_q, cell_q, cnt_q;
  logic [CHW-1:0] chan_q, last_q;
  logic [AW-1:0]  addr_q;
  logic [CW-1:0]  mask_sel, base_sel;

  always_comb begin
    case (casc_cfg)
      8'h01:   mask_sel = M8;
      8'h11:   mask_sel = M4;
      8'h33:   mask_sel = M2;
      default: mask_sel = M1;
    endcase
  end

  assign base_sel = rotate ? (stop_cell & mask_sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      done_q <= 1'b0;
      mask_q <= '0;
      base_q <= '0;
      cell_q <= '0;
      cnt_q  <= '0;
      chan_q <= '0;
      last_q <= '0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (start) begin
          run    <= 1'b1;
          mask_q <= mask_sel;
          base_q <= base_sel;
          cell_q <= base_sel;
          cnt_q  <= '0;
          chan_q <= first_chn;
          last_q <= (last_chn < first_chn) ? first_chn : last_chn;
          addr_q <= '0;
        end
      end else begin
        addr_q <= addr_q + AW'(1);
        if (cnt_q == mask_q) begin
          cnt_q  <= '0;
          cell_q <= base_q;
          if (chan_q == last_q) begin
            run    <= 1'b0;
            done_q <= 1'b1;
          end else begin
            chan_q <= chan_q + CHW'(1);
          end
        end else begin
          cnt_q  <= cnt_q + CW'(1);
          cell_q <= (cell_q + CW'(1)) & mask_q;
        end
      end
    end
  end

  assign busy      = run;
  assign ram_we    = run;
  assign done      = done_q;
  assign cell_idx  = cell_q;
  assign chan_addr = chan_q;
  assign ram_addr  = addr_q;
endmodule

// File: rtl/wave_readout_addr_chk.sv
module wave_readout_addr_chk #(
  parameter int CW  = 13,
  parameter int CHW = 4,
  parameter int AW  = 17
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           ram_we,
  input logic           done,
  input logic [CW-1:0]  cell_idx,
  input logic [CHW-1:0] chan_addr,
  input logic [AW-1:0]  ram_addr
);
  p_start_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> ram_we);

  p_cell_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we) && chan_addr == $past(chan_addr))
      |-> (cell_idx == $past(cell_idx) + CW'(1) || cell_idx == '0));

  p_chan_ascend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we) && chan_addr != $past(chan_addr))
      |-> chan_addr == $past(chan_addr) + CHW'(1));

  p_addr_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we) |-> ram_addr == '0);

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |-> ram_addr == $past(ram_addr) + AW'(1));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ram_we) && !ram_we && !busy));
endmodule

bind wave_readout_addr wave_readout_addr_chk #(.CW(CW), .CHW(CHW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .ram_we(ram_we),
  .done(done), .cell_idx(cell_idx), .chan_addr(chan_addr), .ram_addr(ram_addr)
);

// File: tb/tb_wave_readout_addr.sv
`timescale 1ns/1ps
module tb_wave_readout_addr;
  localparam int CELLS = 8;
  localparam int CHW   = 4;
  localparam int CW    = $clog2(8 * CELLS);
  localparam int AW    = CW + CHW;
  localparam int NV    = 9;

  // {rotate, first[3:0], last[3:0], cfg[7:0], stop[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 4'd0, 4'd3, 8'hFF, 8'd0},
    {1'b1, 4'd2, 4'd4, 8'hFF, 8'd5},
    {1'b0, 4'd1, 4'd2, 8'h33, 8'd0},
    {1'b1, 4'd3, 4'd4, 8'h33, 8'd11},
    {1'b1, 4'd0, 4'd1, 8'h11, 8'd30},
    {1'b1, 4'd5, 4'd5, 8'h01, 8'd63},
    {1'b1, 4'd0, 4'd0, 8'hFF, 8'd45},
    {1'b0, 4'd6, 4'd2, 8'hFF, 8'd3},
    {1'b1, 4'd0, 4'd9, 8'h5A, 8'd7}
  };

  logic clk = 0, rst_n = 0, start = 0, rotate = 0;
  logic [CHW-1:0] first_chn = '0, last_chn = '0;
  logic [7:0] casc_cfg = 8'hFF;
  logic [CW-1:0] stop_cell = '0;
  logic busy, ram_we, done;
  logic [CW-1:0] cell_idx;
  logic [CHW-1:0] chan_addr;
  logic [AW-1:0] ram_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wave_readout_addr #(.CELLS(CELLS), .CHW(CHW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rotate(rotate),
    .first_chn(first_chn), .last_chn(last_chn), .casc_cfg(casc_cfg),
    .stop_cell(stop_cell), .busy(busy), .cell_idx(cell_idx),
    .chan_addr(chan_addr), .ram_addr(ram_addr), .ram_we(ram_we), .done(done)
  );

  function automatic int depth_of(input logic [7:0] c);
    case (c)
      8'h01:   return 8 * CELLS;
      8'h11:   return 4 * CELLS;
      8'h33:   return 2 * CELLS;
      default: return CELLS;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [24:0] v, input bit disturb);
    int d, f, l, s0, n_tot;
    bit bad;
    int bn, bc, be;
    string bw;
    d = depth_of(v[15:8]);
    f = int'(v[23:20]);
    l = int'(v[19:16]);
    if (l < f) l = f;
    s0 = v[24] ? (int'(v[7:0]) % d) : 0;
    n_tot = d * (l - f + 1);
    @(negedge clk);
    rotate = v[24]; first_chn = v[23:20]; last_chn = v[19:16];
    casc_cfg = v[15:8]; stop_cell = CW'(v[7:0]); start = 1;
    @(negedge clk);
    start = 0;
    bad = 0; bn = 0; bc = 0; be = 0; bw = "";
    for (int n = 0; n < n_tot; n++) begin
      int ec, ech;
      ech = f + n / d;
      ec = (s0 + n % d) % d;
      if (!bad) begin
        if (!ram_we || !busy) begin bad = 1; bw = "we"; bc = int'(ram_we); be = 1; end
        else if (int'(cell_idx) != ec) begin bad = 1; bw = "cell"; bc = int'(cell_idx); be = ec; end
        else if (int'(chan_addr) != ech) begin bad = 1; bw = "chan"; bc = int'(chan_addr); be = ech; end
        else if (int'(ram_addr) != n) begin bad = 1; bw = "addr"; bc = int'(ram_addr); be = n; end
        bn = n;
      end
      if (disturb && n == 3) begin
        start = 1; rotate = ~rotate; first_chn = 4'd7; last_chn = 4'd9;
        casc_cfg = 8'h01; stop_cell = CW'(1);
      end
      if (disturb && n == 4) start = 0;
      @(negedge clk);
    end
    // R3 R4 R5 R6 R7 R8 (R2 R10 when disturbed): whole sample sequence
    check(!bad, disturb ? "R2/R10" : "R3-R8 seq", $sformatf("%s at sample %0d", bw, bn), bc, be);
    // R9: done follows the final sample, idle
    check(done && !busy && !ram_we, "R9", "done after last", int'(done), 1);
    @(negedge clk);
    check(!done && !busy, "R9", "done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !ram_we && !done && cell_idx == 0 && chan_addr == 0 && ram_addr == 0,
          "R1", "reset outputs", int'(busy) + int'(ram_we) + int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !ram_we, "R1", "idle without start", int'(busy), 0);
    for (int i = 0; i < NV; i++) run_one(VEC[i], 1'b0);
    // R2 R10: start and configuration changes while busy are ignored
    run_one({1'b1, 4'd1, 4'd3, 8'hFF, 8'd6}, 1'b1);
    run_one({1'b0, 4'd0, 4'd1, 8'h33, 8'd0}, 1'b1);
    // R7: reversed range with rotation
    run_one({1'b1, 4'd9, 4'd1, 8'h11, 8'd17}, 1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule